// File: doc/BRIEF.md
# Periodic ADC/DAC Conversion Sequencer

This block drives a shared parallel I/O bus that has two converters on it: a 10-bit analog-to-digital converter and an 8-bit digital-to-analog converter. It decodes the bus address so that no more than one converter is selected at any time. After reset it writes two configuration words to the ADC. These words set the ADC to use its internal clock, to start a conversion on command and to return plain binary codes. Once both words are written, the block starts serving a programmable periodic tick.

On each accepted tick the block does three things in order. It writes the buffered DAC code to the DAC. It starts an ADC conversion. After a fixed conversion time it pulses a dedicated read strobe, which is separate from the bus write line. It then captures the 10-bit sample into a register that the host can read.

A small host register port gives access to the tick period, the DAC code buffer, the last sample and a status word. Changing the period register is the only way to change the sample rate. A tick that arrives while a conversion is still running is dropped, and it sets an overrun flag.

Top module: `conv_sequencer`

## Requirements
- R1: The ADC select is active only while the converter bus address is 0x0002, and the DAC select only while it is 0x0001. The two selects are never active in the same cycle. The bus address is 0 while neither converter is selected.
- R2: After reset is released, the block idles for one cycle. It then writes 0x00C0 to the ADC and, in the next cycle, writes 0x0100 to the ADC. Both writes happen before any conversion start.
- R3: Host register 0 holds the tick period P, and its reset value is 0. With P nonzero and the configuration writes done, a tick occurs every P cycles. When P is 0, no ticks occur. Writing register 0 restarts the count, so the first tick comes P cycles after the write.
- R4: A tick accepted while idle starts a sequence. In the next cycle the DAC is written with the buffered code in bits 7:0 of the bus data. In the cycle after that, a one-cycle conversion start pulse goes out with the ADC selected.
- R5: CONV_CYCLES+1 cycles after the start pulse, the read strobe is high for one cycle with the ADC selected and no bus write. The ADC data present in that cycle is captured.
- R6: In the cycle after the read strobe, result_valid pulses high for exactly one cycle. Host register 2 then reads the captured sample in bits 9:0, with bits 15:10 equal to zero.
- R7: Host register 3 reads busy in bit 0 and overrun in bit 1. Busy is high from the DAC write cycle to the read-strobe cycle. A tick that arrives while busy starts nothing and sets overrun. Overrun stays set until the host writes register 3.
- R8: Host register 1 holds the DAC code in bits 7:0. A host write to it reaches the DAC only at the next accepted tick, and has no effect on a DAC write that has already happened.
- R9: While reset is asserted, no select, write, start or strobe is active, result_valid is low and all host registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 2 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| io_addr | output | 16 | Converter bus address |
| io_wdata | output | 16 | Converter bus write data |
| io_wr | output | 1 | Converter bus write strobe |
| adc_sel | output | 1 | ADC chip select |
| dac_sel | output | 1 | DAC chip select |
| adc_start | output | 1 | ADC conversion start pulse |
| adc_rdstb | output | 1 | ADC read strobe (dedicated output line) |
| adc_din | input | 10 | ADC sample data |
| result_valid | output | 1 | One-cycle pulse when a new sample is captured |

## Verification
The bench exercises the following cases:

- **Period exactly CONV_CYCLES+4.** This makes sequences run back to back. A design whose busy window is one cycle too long would flag a false overrun here.
- **Shorter period.** A design that accepted ticks while busy would show a second DAC write in the middle of a conversion.
- **DAC code written during a busy sequence.** A design without the staging buffer would change the DAC bus data mid-sequence.
- **Overrun clear.** The bench checks that overrun stays sticky until the host clears it.
- **Zero period.** The bench checks that a zero period stops the ticks.
- **Configuration writes.** The bench checks that both words are written, in order, straight after reset.
- **Sample timing.** The bench checks that the captured sample comes from the strobe cycle and not a cycle earlier or later.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [2:0] {
        S_BOOT, S_CFG0, S_CFG1, S_IDLE, S_DAC, S_START, S_WAIT, S_READ
    } seq_state_e;

    localparam logic [15:0] ADC_CFG_FIRST  = 16'h00C0;
    localparam logic [15:0] ADC_CFG_SECOND = 16'h0100;

    localparam logic [1:0] REG_PERIOD = 2'd0;
    localparam logic [1:0] REG_DAC    = 2'd1;
    localparam logic [1:0] REG_RESULT = 2'd2;
    localparam logic [1:0] REG_STATUS = 2'd3;
endpackage

// File: rtl/cs_timer.sv
module cs_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          restart,
    input  logic [PW-1:0] period,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;
    logic run;

    always_comb begin
        d    = q;
        run  = enable && (period != '0);
        tick = run && (q.cnt == period - PW'(1));
        if (restart)
            d.cnt = '0;
        else if (run)
            d.cnt = tick ? '0 : q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: no tick while stopped
    a_r3_no_tick_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !tick);
endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
    parameter int AW       = 16,
    parameter int ADC_ADDR = 2,
    parameter int DAC_ADDR = 1
) (
    input  logic          active,
    input  logic [AW-1:0] addr,
    output logic          adc_sel,
    output logic          dac_sel
);
    localparam logic [AW-1:0] ADC_A = AW'(ADC_ADDR);
    localparam logic [AW-1:0] DAC_A = AW'(DAC_ADDR);

    always_comb begin
        adc_sel = active && (addr == ADC_A);
        dac_sel = active && (addr == DAC_A);
    end
endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
    import conv_seq_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CONV_CYCLES = 4,
    parameter int ADC_ADDR    = 2,
    parameter int DAC_ADDR    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [7:0]    dac_word,
    output logic          bus_active,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wr,
    output logic [15:0]   bus_wdata,
    output logic          adc_start,
    output logic          adc_rdstb,
    output logic          capture,
    output logic          busy,
    output logic          ready,
    output logic          overrun_evt
);
    localparam int WW = $clog2(CONV_CYCLES + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(CONV_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [WW-1:0] wcnt;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d           = q;
        bus_active  = 1'b0;
        bus_addr    = '0;
        bus_wr      = 1'b0;
        bus_wdata   = '0;
        adc_start   = 1'b0;
        adc_rdstb   = 1'b0;
        capture     = 1'b0;
        busy        = q.state inside {S_DAC, S_START, S_WAIT, S_READ};
        ready       = busy || (q.state == S_IDLE);
        overrun_evt = tick && busy;
        case (q.state)
            S_BOOT:  d.state = S_CFG0;
            S_CFG0: begin
                bus_active = 1'b1;
                bus_addr   = AW'(ADC_ADDR);
                bus_wr     = 1'b1;
                bus_wdata  = ADC_CFG_FIRST;
                d.state    = S_CFG1;
            end
            S_CFG1: begin
                bus_active = 1'b1;
                bus_addr   = AW'(ADC_ADDR);
                bus_wr     = 1'b1;
                bus_wdata  = ADC_CFG_SECOND;
                d.state    = S_IDLE;
            end
            S_IDLE:  if (tick) d.state = S_DAC;
            S_DAC: begin
                bus_active = 1'b1;
                bus_addr   = AW'(DAC_ADDR);
                bus_wr     = 1'b1;
                bus_wdata  = {8'h00, dac_word};
                d.state    = S_START;
            end
            S_START: begin
                bus_active = 1'b1;
                bus_addr   = AW'(ADC_ADDR);
                adc_start  = 1'b1;
                d.wcnt     = '0;
                d.state    = S_WAIT;
            end
            S_WAIT: begin
                if (q.wcnt == WAIT_LAST) d.state = S_READ;
                else                     d.wcnt  = q.wcnt + WW'(1);
            end
            S_READ: begin
                bus_active = 1'b1;
                bus_addr   = AW'(ADC_ADDR);
                adc_rdstb  = 1'b1;
                capture    = 1'b1;
                d.state    = S_IDLE;
            end
            default: d.state = S_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= S_BOOT;
            q.wcnt  <= '0;
        end else begin
            q <= d;
        end
    end

    // R5: the conversion wait stays within its window
    a_r5_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_WAIT) |-> (q.wcnt <= WAIT_LAST));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int PW          = 16,
    parameter int CONV_CYCLES = 4,
    parameter int DEF_PERIOD  = 0,
    parameter int ADC_ADDR    = 2,
    parameter int DAC_ADDR    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic [15:0] io_addr,
    output logic [15:0] io_wdata,
    output logic        io_wr,
    output logic        adc_sel,
    output logic        dac_sel,
    output logic        adc_start,
    output logic        adc_rdstb,
    input  logic [9:0]  adc_din,
    output logic        result_valid
);
    localparam int AW = 16;

    typedef struct packed {
        logic [PW-1:0] period;
        logic [7:0]    stage;
        logic [9:0]    result;
        logic          valid;
        logic          ovr;
    } regs_t;

    regs_t q, d;

    logic tick, period_wr, bus_active, capture, busy, ready, overrun_evt;

    cs_timer #(.PW(PW)) timer_i (
        .clk(clk), .rst_n(rst_n), .enable(ready), .restart(period_wr),
        .period(q.period), .tick(tick)
    );

    cs_fsm #(.AW(AW), .CONV_CYCLES(CONV_CYCLES), .ADC_ADDR(ADC_ADDR), .DAC_ADDR(DAC_ADDR)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dac_word(q.stage),
        .bus_active(bus_active), .bus_addr(io_addr), .bus_wr(io_wr), .bus_wdata(io_wdata),
        .adc_start(adc_start), .adc_rdstb(adc_rdstb), .capture(capture),
        .busy(busy), .ready(ready), .overrun_evt(overrun_evt)
    );

    cs_decode #(.AW(AW), .ADC_ADDR(ADC_ADDR), .DAC_ADDR(DAC_ADDR)) dec_i (
        .active(bus_active), .addr(io_addr), .adc_sel(adc_sel), .dac_sel(dac_sel)
    );

    always_comb begin
        d         = q;
        period_wr = host_we && (host_addr == REG_PERIOD);
        d.valid   = capture;
        if (capture) d.result = adc_din;
        if (host_we) begin
            case (host_addr)
                REG_PERIOD: d.period = PW'(host_wdata);
                REG_DAC:    d.stage  = host_wdata[7:0];
                REG_STATUS: d.ovr    = 1'b0;
                default:    ;
            endcase
        end
        if (overrun_evt) d.ovr = 1'b1;

        case (host_addr)
            REG_PERIOD: host_rdata = 16'(q.period);
            REG_DAC:    host_rdata = {8'h00, q.stage};
            REG_RESULT: host_rdata = {6'h00, q.result};
            default:    host_rdata = {14'h0, q.ovr, busy};
        endcase
        result_valid = q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.period <= PW'(DEF_PERIOD);
        end else begin
            q <= d;
        end
    end

    // Assertion support: remembers that the second configuration word went out
    logic cfg_done_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                                  cfg_done_q <= 1'b0;
        else if (adc_sel && io_wr && io_wdata == ADC_CFG_SECOND)     cfg_done_q <= 1'b1;
    end

    // R1: never both converters selected
    a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adc_sel, dac_sel}));
    // R2: second configuration word directly follows the first
    a_r2_cfg_order: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sel && io_wr && io_wdata == ADC_CFG_SECOND) |->
            $past(adc_sel && io_wr && io_wdata == ADC_CFG_FIRST));
    // R2: no conversion start before configuration completes
    a_r2_start_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> cfg_done_q);
    // R4: DAC write is followed by the ADC start
    a_r4_dac_then_start: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sel && io_wr) |=> (adc_start && adc_sel));
    // R5: read strobe only with ADC selected and no bus write
    a_r5_strobe_clean: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rdstb |-> (adc_sel && !io_wr));
    // R6: valid is a single-cycle pulse
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R7: a tick while busy leaves overrun set
    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && busy) |=> q.ovr);
endmodule

// File: tb/conv_sequencer_tb_top.sv
module conv_sequencer_tb_top;
    localparam int C = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata, io_addr, io_wdata;
    logic        io_wr, adc_sel, dac_sel, adc_start, adc_rdstb, result_valid;
    logic [9:0]  adc_din = 10'h0;

    always #4 clk = ~clk;

    conv_sequencer #(.CONV_CYCLES(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_wr(io_wr), .adc_sel(adc_sel), .dac_sel(dac_sel),
        .adc_start(adc_start), .adc_rdstb(adc_rdstb), .adc_din(adc_din),
        .result_valid(result_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural reference state
    int m_init, m_cnt, m_period, m_stage, m_seq, m_res, m_valid, m_ovr;

    task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_init = 0; m_cnt = 0; m_period = 0; m_stage = 0;
        m_seq = -1; m_res = 0; m_valid = 0; m_ovr = 0;
    endtask

    initial begin
        model_reset();
        for (int k = -4; k < 380; k++) begin
            int e_addr, e_data, e_wr, e_adc, e_dac, e_start, e_rd, e_busy, e_rdata;
            bit tick, run, busy_now, ready_now;
            @(negedge clk);
            rst_n      = (k >= 0);
            host_we    = 1'b0;
            host_addr  = 2'((k < 0) ? 0 : k);
            host_wdata = 16'h0;
            adc_din    = 10'((k + 8) * 97 + 13);
            if (k == 200) adc_din = 10'h3FF;
            case (k)
                5:   begin host_we = 1; host_addr = 0; host_wdata = 16'd10;  end // R3
                6:   begin host_we = 1; host_addr = 1; host_wdata = 16'hFF5A; end // R8
                17:  begin host_we = 1; host_addr = 1; host_wdata = 16'h00A5; end // R8 mid-sequence
                120: begin host_we = 1; host_addr = 0; host_wdata = 16'd0;   end // R3 stop
                150: begin host_we = 1; host_addr = 1; host_wdata = 16'h0033; end
                160: begin host_we = 1; host_addr = 0; host_wdata = 16'd5;   end // R7 overrun
                230: begin host_we = 1; host_addr = 0; host_wdata = 16'd0;   end
                260: begin host_we = 1; host_addr = 3; host_wdata = 16'h0;   end // R7 clear
                280: begin host_we = 1; host_addr = 0; host_wdata = 16'd8;   end // R7 boundary
                340: begin host_we = 1; host_addr = 0; host_wdata = 16'd0;   end
                default: ;
            endcase
            #1;
            if (!rst_n) model_reset();

            e_addr = 0; e_data = 0; e_wr = 0; e_adc = 0; e_dac = 0; e_start = 0; e_rd = 0;
            if (m_init == 1 || m_init == 2) begin
                e_addr = 2; e_adc = 1; e_wr = 1; e_data = (m_init == 1) ? 'h00C0 : 'h0100;
            end else if (m_seq == 0) begin
                e_addr = 1; e_dac = 1; e_wr = 1; e_data = m_stage;
            end else if (m_seq == 1) begin
                e_addr = 2; e_adc = 1; e_start = 1;
            end else if (m_seq == 2 + C) begin
                e_addr = 2; e_adc = 1; e_rd = 1;
            end
            e_busy = (m_seq >= 0) ? 1 : 0;
            case (host_addr)
                2'd0: e_rdata = m_period;
                2'd1: e_rdata = m_stage;
                2'd2: e_rdata = m_res;
                default: e_rdata = (m_ovr << 1) | e_busy;
            endcase

            chk(rst_n ? "R1" : "R9", "io_addr", 32'(io_addr), 32'(e_addr));
            chk(rst_n ? "R1" : "R9", "adc_sel", 32'(adc_sel), 32'(e_adc));
            chk(rst_n ? "R1" : "R9", "dac_sel", 32'(dac_sel), 32'(e_dac));
            chk(rst_n ? "R2" : "R9", "io_wr", 32'(io_wr), 32'(e_wr));
            chk(rst_n ? "R8" : "R9", "io_wdata", 32'(io_wdata), 32'(e_data));
            chk(rst_n ? "R4" : "R9", "adc_start", 32'(adc_start), 32'(e_start));
            chk(rst_n ? "R5" : "R9", "adc_rdstb", 32'(adc_rdstb), 32'(e_rd));
            chk(rst_n ? "R6" : "R9", "result_valid", 32'(result_valid), 32'(m_valid));
            chk(rst_n ? "R7" : "R9", "host_rdata", 32'(host_rdata), 32'(e_rdata));

            if (rst_n) begin
                ready_now = (m_init == 3);
                busy_now  = (m_seq >= 0);
                run       = ready_now && (m_period != 0);
                tick      = run && (m_cnt == m_period - 1);
                if (host_we && host_addr == 2'd0) m_cnt = 0;
                else if (run) m_cnt = tick ? 0 : m_cnt + 1;
                m_valid = 0;
                if (m_seq < 0) begin
                    if (tick) m_seq = 0;
                end else if (m_seq == 2 + C) begin
                    m_seq = -1; m_res = int'(adc_din); m_valid = 1;
                end else begin
                    m_seq++;
                end
                if (host_we && host_addr == 2'd3) m_ovr = 0;
                if (tick && busy_now) m_ovr = 1;
                if (host_we && host_addr == 2'd0) m_period = int'(host_wdata);
                if (host_we && host_addr == 2'd1) m_stage = int'(host_wdata[7:0]);
                if (m_init < 3) m_init++;
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < 20000; w++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule